// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core (Ten-Instruction Subset)

This block is a single-cycle processor core that carries out one instruction per clock from a small 32-bit load/store instruction set: word load and store, add-immediate, register add and subtract, signed set-on-less-than, branch-if-equal, absolute jump, jump-and-link and jump-through-register. Each instruction is fetched, decoded, executed and retired within one clock period, so the program counter, the register file and the data memory all update on the same rising edge.

The core owns its instruction store and data store, 1024 words each, addressed by word through bits [11:2] of a byte address. The instruction store is filled from outside before reset is released. Apart from clock and reset, the core has only observation taps: the current program counter and the register-file write taking place in the current cycle. An integration bench or a trace monitor uses these taps to follow the retirement stream.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears all 32 registers, so the first instruction after reset reads zeros from every register.
- R2: Any instruction that does not redirect control advances the program counter by exactly 4 on the next clock.
- R3: Add-immediate (primary opcode 001000) adds the sign-extended 16-bit immediate (bits [15:0]) to register rs (bits [25:21]) and writes the sum to register rt (bits [20:16]).
- R4: With primary opcode 000000, function code 100000 writes rs+rt and function code 100010 writes rs-rt to register rd (bits [15:11]), with 32-bit wrap-around.
- R5: With primary opcode 000000 and function code 101010, register rd receives 1 when rs is less than rt as signed two's-complement values and 0 otherwise.
- R6: Store-word (opcode 101011) writes rt into the data word at byte address rs+sign-extended immediate, word index taken from bits [11:2]; load-word (opcode 100011) returns the word at that address into register rt.
- R7: Branch-if-equal (opcode 000100) loads PC+4 plus the sign-extended immediate shifted left by 2 when rs equals rt, and PC+4 otherwise; the offset may be negative.
- R8: Jump (opcode 000010) loads the program counter with bits [31:28] of PC+4, followed by the 26-bit index (bits [25:0]), followed by two zero bits.
- R9: Jump-and-link (opcode 000011) forms the same target as R8 and writes PC+4 into register 31 in the same cycle.
- R10: With primary opcode 000000 and function code 001000, the program counter is loaded with the value of register rs and no register is written.
- R11: Any other opcode, or any other function code under opcode 000000, writes neither the register file nor the data memory, and the program counter advances by 4.
- R12: A write aimed at register 0 is discarded and is not shown on the write tap; register 0 always reads as 0.
- R13: Store-word, branch-if-equal and jump write no register; the write tap stays low for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Program counter of the instruction executing this cycle |
| dbg_rf_we | output | 1 | High when this cycle's instruction writes a register other than register 0 |
| dbg_rf_wa | output | 5 | Destination register number of that write |
| dbg_rf_wd | output | 32 | Value written to that register |

## Verification
Every result of an instruction is visible on the taps in two places: the register write is shown combinationally during the cycle that instruction is at dbg_pc, and the next-PC decision is shown on dbg_pc one rising edge later. The bench therefore samples on the falling edge, checking the write tap against an instruction-set model for the instruction currently at dbg_pc and checking dbg_pc against the target the model computed for the previous instruction. A store becomes visible only through a later load, so the program places a load of the same address directly after the store and the model charges that check to the memory requirement.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int RAW     = $clog2(NREGS);
    localparam int LINKREG = NREGS - 1;

    localparam logic [5:0] OP_SPECIAL = 6'b000000;
    localparam logic [5:0] OP_JUMP    = 6'b000010;
    localparam logic [5:0] OP_JLINK   = 6'b000011;
    localparam logic [5:0] OP_BEQ     = 6'b000100;
    localparam logic [5:0] OP_ADDI    = 6'b001000;
    localparam logic [5:0] OP_LOADW   = 6'b100011;
    localparam logic [5:0] OP_STOREW  = 6'b101011;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_SLT = 6'b101010;
    localparam logic [5:0] FN_JR  = 6'b001000;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT} alu_op_e;
    typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_sel_e;
    typedef enum logic [1:0] {SRC_ALU, SRC_MEM, SRC_LINK} src_sel_e;
    typedef enum logic [1:0] {NXT_SEQ, NXT_BRANCH, NXT_JUMP, NXT_REG} nxt_sel_e;

    typedef struct packed {
        logic     rs_re;
        logic     rt_re;
        logic     rf_we;
        logic     dm_we;
        logic     dm_re;
        logic     b_imm;
        logic     illegal;
        alu_op_e  alu_op;
        dst_sel_e dst;
        src_sel_e src;
        nxt_sel_e nxt;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]  op;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [4:0]  sh;
        logic [5:0]  fn;
    } insn_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] seq,
                                                    input logic [15:0] off);
        return seq + (sext16(off) << 2);
    endfunction

    function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] seq,
                                                  input logic [25:0] idx);
        return {seq[XLEN-1:XLEN-4], idx, 2'b00};
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] fn,
    output ctrl_t      ctl
);
    always_comb begin
        ctl         = '0;
        ctl.alu_op  = ALU_ADD;
        ctl.dst     = DST_RT;
        ctl.src     = SRC_ALU;
        ctl.nxt     = NXT_SEQ;
        unique case (op)
            OP_LOADW: begin
                ctl.rs_re = 1'b1;
                ctl.b_imm = 1'b1;
                ctl.dm_re = 1'b1;
                ctl.rf_we = 1'b1;
                ctl.src   = SRC_MEM;
            end
            OP_STOREW: begin
                ctl.rs_re = 1'b1;
                ctl.rt_re = 1'b1;
                ctl.b_imm = 1'b1;
                ctl.dm_we = 1'b1;
            end
            OP_ADDI: begin
                ctl.rs_re = 1'b1;
                ctl.b_imm = 1'b1;
                ctl.rf_we = 1'b1;
            end
            OP_BEQ: begin
                ctl.rs_re = 1'b1;
                ctl.rt_re = 1'b1;
                ctl.nxt   = NXT_BRANCH;
            end
            OP_JUMP: begin
                ctl.nxt = NXT_JUMP;
            end
            OP_JLINK: begin
                ctl.nxt   = NXT_JUMP;
                ctl.rf_we = 1'b1;
                ctl.dst   = DST_LINK;
                ctl.src   = SRC_LINK;
            end
            OP_SPECIAL: begin
                unique case (fn)
                    FN_ADD, FN_SUB, FN_SLT: begin
                        ctl.rs_re  = 1'b1;
                        ctl.rt_re  = 1'b1;
                        ctl.rf_we  = 1'b1;
                        ctl.dst    = DST_RD;
                        ctl.alu_op = (fn == FN_ADD) ? ALU_ADD :
                                     (fn == FN_SUB) ? ALU_SUB : ALU_SLT;
                    end
                    FN_JR: begin
                        ctl.rs_re = 1'b1;
                        ctl.nxt   = NXT_REG;
                    end
                    default: ctl.illegal = 1'b1;
                endcase
            end
            default: ctl.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    logic [XLEN-1:0] diff;
    logic            lt;

    always_comb begin
        diff = a - b;
        lt   = $signed(a) < $signed(b);
        unique case (op)
            ALU_SUB: y = diff;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, lt};
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ra_en,
    input  logic [RAW-1:0]  ra_addr,
    output logic [XLEN-1:0] ra_data,
    input  logic            rb_en,
    input  logic [RAW-1:0]  rb_addr,
    output logic [XLEN-1:0] rb_data,
    input  logic            w_en,
    input  logic [RAW-1:0]  w_addr,
    input  logic [XLEN-1:0] w_data
);
    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (w_en && (w_addr != '0)) begin
            regs[w_addr] <= w_data;
        end
    end

    always_comb begin
        ra_data = (ra_en && (ra_addr != '0)) ? regs[ra_addr] : '0;
        rb_data = (rb_en && (rb_addr != '0)) ? regs[rb_addr] : '0;
    end
endmodule

// File: rtl/sc_wmem.sv
module sc_wmem
    import sc_pkg::*;
#(
    parameter int WORDS = 1024
) (
    input  logic            clk,
    input  logic            re,
    input  logic [XLEN-1:0] raddr,
    output logic [XLEN-1:0] rdata,
    input  logic            we,
    input  logic [XLEN-1:0] waddr,
    input  logic [XLEN-1:0] wdata
);
    localparam int AW = $clog2(WORDS);

    logic [XLEN-1:0] mem [WORDS];
    logic [AW-1:0]   ridx;
    logic [AW-1:0]   widx;
    logic            unused_addr_bits;

    assign ridx = raddr[AW+1:2];
    assign widx = waddr[AW+1:2];
    assign unused_addr_bits = ^{raddr[XLEN-1:AW+2], raddr[1:0],
                                waddr[XLEN-1:AW+2], waddr[1:0]};

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = re ? mem[ridx] : '0;
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 1024,
    parameter int DMEM_WORDS = 1024
) (
    input  logic            clk,
    input  logic            rst,
    output logic [31:0]     dbg_pc,
    output logic            dbg_rf_we,
    output logic [4:0]      dbg_rf_wa,
    output logic [31:0]     dbg_rf_wd
);
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] pc_nxt;
    logic [XLEN-1:0] ir;
    insn_t           fld;
    ctrl_t           ctl;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] imm;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] dm_rdata;
    logic [RAW-1:0]  wr_addr;
    logic [XLEN-1:0] wr_data;
    logic            unused_shamt;

    assign fld          = insn_t'(ir);
    assign unused_shamt = ^fld.sh;
    assign pc_seq       = pc_q + XLEN'(4);
    assign imm          = sext16(ir[15:0]);

    sc_wmem #(.WORDS(IMEM_WORDS)) u_imem (
        .clk   (clk),
        .re    (1'b1),
        .raddr (pc_q),
        .rdata (ir),
        .we    (1'b0),
        .waddr ('0),
        .wdata ('0)
    );

    sc_decode u_dec (
        .op  (fld.op),
        .fn  (fld.fn),
        .ctl (ctl)
    );

    sc_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_en   (ctl.rs_re),
        .ra_addr (fld.rs),
        .ra_data (rs_val),
        .rb_en   (ctl.rt_re),
        .rb_addr (fld.rt),
        .rb_data (rt_val),
        .w_en    (ctl.rf_we),
        .w_addr  (wr_addr),
        .w_data  (wr_data)
    );

    assign alu_b = ctl.b_imm ? imm : rt_val;

    sc_alu u_alu (
        .op (ctl.alu_op),
        .a  (rs_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    sc_wmem #(.WORDS(DMEM_WORDS)) u_dmem (
        .clk   (clk),
        .re    (ctl.dm_re),
        .raddr (alu_y),
        .rdata (dm_rdata),
        .we    (ctl.dm_we),
        .waddr (alu_y),
        .wdata (rt_val)
    );

    always_comb begin
        unique case (ctl.dst)
            DST_RD:   wr_addr = fld.rd;
            DST_LINK: wr_addr = RAW'(LINKREG);
            default:  wr_addr = fld.rt;
        endcase
        unique case (ctl.src)
            SRC_MEM:  wr_data = dm_rdata;
            SRC_LINK: wr_data = pc_seq;
            default:  wr_data = alu_y;
        endcase
    end

    always_comb begin
        unique case (ctl.nxt)
            NXT_BRANCH: pc_nxt = (rs_val == rt_val) ? branch_dest(pc_seq, ir[15:0]) : pc_seq;
            NXT_JUMP:   pc_nxt = jump_dest(pc_seq, ir[25:0]);
            NXT_REG:    pc_nxt = rs_val;
            default:    pc_nxt = pc_seq;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_nxt;
    end

    assign dbg_pc    = pc_q;
    assign dbg_rf_we = ctl.rf_we && (wr_addr != '0);
    assign dbg_rf_wa = wr_addr;
    assign dbg_rf_wd = wr_data;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [31:0]     pc,
    input logic            wr_tap,
    input logic [4:0]      wa_tap,
    input logic [31:0]     wd_tap,
    input ctrl_t           ctl,
    input logic [4:0]      rs_idx,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] dm_rdata
);
    p_pc_cleared_r1: assert property (@(posedge clk)
        $past(rst) |-> (pc == '0));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl.nxt == NXT_SEQ) |=> (pc == $past(pc) + 32'd4));

    p_link_value_r9: assert property (@(posedge clk) disable iff (rst)
        (ctl.dst == DST_LINK) |-> (wr_tap && wa_tap == 5'd31 && wd_tap == pc + 32'd4));

    p_unknown_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        ctl.illegal |-> (!wr_tap && !ctl.dm_we && !ctl.rf_we));

    p_unknown_step_r11: assert property (@(posedge clk) disable iff (rst)
        ctl.illegal |=> (pc == $past(pc) + 32'd4));

    p_zero_reg_r12: assert property (@(posedge clk) disable iff (rst)
        (rs_idx == 5'd0) |-> (rs_val == '0));

    p_no_tap_zero_r12: assert property (@(posedge clk) disable iff (rst)
        wr_tap |-> (wa_tap != 5'd0));

    p_dm_gated_r6: assert property (@(posedge clk) disable iff (rst)
        !ctl.dm_re |-> (dm_rdata == '0));

    p_no_write_r13: assert property (@(posedge clk) disable iff (rst)
        (ctl.dm_we || ctl.nxt == NXT_BRANCH) |-> !wr_tap);
endmodule

bind sc_core sc_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc       (dbg_pc),
    .wr_tap   (dbg_rf_we),
    .wa_tap   (dbg_rf_wa),
    .wd_tap   (dbg_rf_wd),
    .ctl      (ctl),
    .rs_idx   (fld.rs),
    .rs_val   (rs_val),
    .dm_rdata (dm_rdata)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dbg_pc;
    logic        dbg_rf_we;
    logic [4:0]  dbg_rf_wa;
    logic [31:0] dbg_rf_wd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    sc_core u0 (
        .clk       (clk),
        .rst       (rst),
        .dbg_pc    (dbg_pc),
        .dbg_rf_we (dbg_rf_we),
        .dbg_rf_wa (dbg_rf_wa),
        .dbg_rf_wd (dbg_rf_wd)
    );

    // instruction builders
    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(input logic [5:0] op, input int idx);
        return {op, 26'(idx)};
    endfunction

    // instruction-set model state
    logic [31:0] prog [1024];
    logic [31:0] mreg [32];
    logic [31:0] mdm  [1024];
    logic [31:0] mpc;
    logic        e_we;
    logic [4:0]  e_wa;
    logic [31:0] e_wd;
    logic [31:0] e_npc;
    string       tag_w;
    string       tag_pc;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at pc=%h: actual=%h expected=%h", req, what, mpc, act, exp);
        end
    endtask

    // evaluate the current instruction in the model
    task automatic model_eval();
        logic [31:0] ins, a, b, imm, seq, addr;
        logic [5:0]  op, fn;
        ins  = prog[mpc[11:2]];
        op   = ins[31:26];
        fn   = ins[5:0];
        a    = mreg[ins[25:21]];
        b    = mreg[ins[20:16]];
        imm  = {{16{ins[15]}}, ins[15:0]};
        seq  = mpc + 32'd4;
        addr = a + imm;
        e_we = 1'b0; e_wa = 5'd0; e_wd = 32'd0; e_npc = seq;
        tag_w = "R11";
        case (op)
            6'b000000: begin
                case (fn)
                    6'b100000: begin e_we = 1; e_wa = ins[15:11]; e_wd = a + b; tag_w = "R4"; end
                    6'b100010: begin e_we = 1; e_wa = ins[15:11]; e_wd = a - b; tag_w = "R4"; end
                    6'b101010: begin e_we = 1; e_wa = ins[15:11];
                                     e_wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag_w = "R5"; end
                    6'b001000: begin e_npc = a; tag_w = "R10"; end
                    default: ;
                endcase
            end
            6'b001000: begin e_we = 1; e_wa = ins[20:16]; e_wd = addr; tag_w = "R3"; end
            6'b100011: begin e_we = 1; e_wa = ins[20:16]; e_wd = mdm[addr[11:2]]; tag_w = "R6"; end
            6'b101011: begin mdm[addr[11:2]] = b; tag_w = "R13"; end
            6'b000100: begin if (a == b) e_npc = seq + (imm << 2); tag_w = "R7"; end
            6'b000010: begin e_npc = {seq[31:28], ins[25:0], 2'b00}; tag_w = "R8"; end
            6'b000011: begin e_npc = {seq[31:28], ins[25:0], 2'b00};
                             e_we = 1; e_wa = 5'd31; e_wd = seq; tag_w = "R9"; end
            default: ;
        endcase
        if (e_we && e_wa == 5'd0) begin
            e_we  = 1'b0;
            tag_w = "R12";
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin prog[i] = 32'd0; mdm[i] = 32'd0; end
        for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
        prog[0]  = enc_r(1, 2, 3, 6'b100000);          // add  r3 = r1 + r2 after reset (0)
        prog[1]  = enc_i(6'b001000, 0, 1, 5);          // addi r1 = 5
        prog[2]  = enc_i(6'b001000, 0, 2, -3);         // addi r2 = -3
        prog[3]  = enc_r(1, 2, 3, 6'b100000);          // add  r3 = 2
        prog[4]  = enc_r(2, 1, 4, 6'b100010);          // sub  r4 = -8
        prog[5]  = enc_r(2, 1, 5, 6'b101010);          // slt  -3 < 5 -> 1
        prog[6]  = enc_r(1, 2, 6, 6'b101010);          // slt  5 < -3 -> 0
        prog[7]  = enc_i(6'b001000, 0, 0, 7);          // addi r0 (discarded)
        prog[8]  = enc_r(0, 1, 7, 6'b100000);          // add  r7 = r0 + r1 = 5
        prog[9]  = enc_i(6'b001000, 0, 8, 256);        // addi r8 = 0x100
        prog[10] = enc_i(6'b101011, 8, 4, 8);          // sw   r4 -> 0x108
        prog[11] = enc_i(6'b100011, 8, 9, 8);          // lw   r9 <- 0x108
        prog[12] = {6'b111111, 5'd1, 5'd2, 16'h0008};  // unknown opcode
        prog[13] = enc_i(6'b000100, 1, 2, 5);          // beq  not taken
        prog[14] = enc_i(6'b000100, 1, 7, 2);          // beq  taken -> 68
        prog[15] = enc_i(6'b001000, 0, 11, 99);        // skipped
        prog[16] = enc_i(6'b001000, 0, 11, 98);        // skipped
        prog[17] = enc_j(6'b000011, 25);               // jal  -> 100, r31 = 72
        prog[18] = enc_j(6'b000010, 30);               // j    -> 120
        prog[19] = enc_r(1, 2, 3, 6'b000111);          // unknown function (unreached)
        prog[25] = enc_i(6'b001000, 0, 12, -1);        // addi r12 = -1
        prog[26] = enc_r(4, 2, 13, 6'b101010);         // slt  -8 < -3 -> 1
        prog[27] = enc_r(2, 4, 14, 6'b100010);         // sub  r14 = 5
        prog[28] = enc_r(1, 2, 15, 6'b000111);         // unknown function code
        prog[29] = enc_r(31, 0, 0, 6'b001000);         // jr   r31 -> 72
        prog[30] = enc_i(6'b000100, 0, 0, -1);         // beq  r0,r0 back to itself
        for (int i = 0; i < 1024; i++) u0.u_imem.mem[i] = prog[i];

        repeat (3) @(negedge clk);
        #1;
        check("R1", "pc in reset", dbg_pc, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        mpc    = 32'd0;
        tag_pc = "R1";
        for (int cyc = 0; cyc < 60; cyc++) begin
            check(tag_pc, "pc", dbg_pc, mpc);
            model_eval();
            check(cyc == 0 ? "R1" : tag_w, "write enable", {31'd0, dbg_rf_we}, {31'd0, e_we});
            if (e_we) begin
                check(tag_w, "write address", {27'd0, dbg_rf_wa}, {27'd0, e_wa});
                check(cyc == 0 ? "R1" : tag_w, "write data", dbg_rf_wd, e_wd);
                mreg[e_wa] = e_wd;
            end
            tag_pc = (e_npc == mpc + 32'd4 && tag_w != "R7" && tag_w != "R10") ? "R2" : tag_w;
            if (tag_w == "R11") tag_pc = "R11";
            mpc = e_npc;
            @(negedge clk);
            #1;
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule